// File: doc/BRIEF.md
# Supply Reset Sequencer

This block is the digital sequencer of a processor supply supervisor. Analog comparators outside the block supply three results: the main supply is below its primary trip point, a second monitored rail is below its own trip point, and the backup cell is above the main supply. A raw pushbutton line for manual reset also comes in. From these, the block drives a system reset, an undelayed early-warning flag, a second-rail-good flag and a control that selects the backup cell as the source for the protected output rail.

Each comparator input and the pushbutton pass through a two-flop synchronizer. The pushbutton must then hold a level for a set number of cycles before that level counts. The reset has two possible causes: a low main supply or an accepted press. After both causes clear, the reset stays asserted for a stabilization window. If either cause comes back during the window, the window starts again. The warning flags and the battery select are registered straight from the synchronized comparators, with no added delay.

In the requirements, edge k is the rising clock edge at which an input is first sampled. Inputs with a suffix _i are active high. The pushbutton line is low while pressed.

Top module: `supply_sequencer`

## Requirements
- R1: While `rst` is high, the reset output is active, `vcc_warn_o` is 1, `aux_ok_o` is 0 and `batt_sel_o` is 0. These values hold until synchronized comparator samples reach the output registers.
- R2: After edge k+2, `vcc_warn_o` equals the value of `vcc_low_i` sampled at edge k.
- R3: After edge k+2, `aux_ok_o` equals the inverse of `aux_low_i` sampled at edge k. The output is 0 while the second rail is low and 1 otherwise.
- R4: After edge k+2, `batt_sel_o` is 1 only if `vcc_low_i` and `batt_gt_vcc_i` were both 1 at edge k. Otherwise it is 0, and the main supply feeds the output rail.
- R5: If `vcc_low_i` is 1 at edge k, the internal reset is active after edge k+2. It stays active for as long as the input stays 1.
- R6: Once every reset cause has cleared, the reset stays active for exactly STAB_CYCLES further edges. A cause that returns inside that window restarts the full window.
- R7: A pushbutton level is accepted only after the synchronized line has differed from the accepted level on DEB_CYCLES consecutive edges. A shorter pulse or a bounce has no effect on the reset output.
- R8: An accepted press (level 0) is a reset cause. After an accepted release, the reset is stretched by the R6 window.
- R9: With RST_ACTIVE_LOW = 1, `sys_rst_o` is 0 while reset is active. With RST_ACTIVE_LOW = 0, it is 1 while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_low_i | input | 1 | Main supply below primary trip point |
| aux_low_i | input | 1 | Second monitored rail below its trip point |
| batt_gt_vcc_i | input | 1 | Backup cell voltage above main supply |
| mr_btn_n_i | input | 1 | Raw manual-reset pushbutton, low when pressed |
| sys_rst_o | output | 1 | System reset, polarity set by RST_ACTIVE_LOW |
| vcc_warn_o | output | 1 | Early low-supply flag, 1 while the main supply is low |
| aux_ok_o | output | 1 | Second rail good, 0 while that rail is low |
| batt_sel_o | output | 1 | 1 selects the backup cell for the output rail |

## Verification
The bench builds the block with STAB_CYCLES = 40, DEB_CYCLES = 8 and RST_ACTIVE_LOW = 1. These small values replace the roughly 200 ms default window and let a run cover a complete stretch, a restart in the middle of the window, bounces shorter than the debounce length and accepted presses many times. Random stimulus changes the supply and pushbutton inputs slowly enough that stretched resets often run to the end, and often enough that restarts and overlapping causes occur. The active-low setting exercises the inverted reset pin.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
  // synchronized view of the comparator and pushbutton lines
  typedef struct packed {
    logic vcc_low;
    logic aux_low;
    logic batt_gt;
    logic btn_n;
  } cmp_t;

  localparam int CMP_W = $bits(cmp_t);

  // pessimistic power-on view: supplies low, no battery, button released
  localparam cmp_t CMP_RST = '{vcc_low: 1'b1, aux_low: 1'b1, batt_gt: 1'b0, btn_n: 1'b1};
endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
module sup_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
`timescale 1ns/1ps
module sup_debounce #(
  parameter int DEB_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      cnt   <= '0;
    end else if (raw == level) begin
      cnt <= '0;
    end else if (cnt == CW'(DEB_CYCLES - 1)) begin
      level <= raw;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  level_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> ($past(cnt) == CW'(DEB_CYCLES - 1)));
endmodule

// File: rtl/sup_stretch.sv
`timescale 1ns/1ps
module sup_stretch #(
  parameter int STAB_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic active
);
  localparam int CW = $clog2(STAB_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CW'(STAB_CYCLES - 1)) active <= 1'b0;
      else                             cnt    <= cnt + 1'b1;
    end
  end

  // R5
  hold_forces_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> active);

  // R6
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(!hold) && $past(cnt) == CW'(STAB_CYCLES - 1)));
endmodule

// File: rtl/supply_sequencer.sv
`timescale 1ns/1ps
module supply_sequencer #(
  parameter int STAB_CYCLES    = 50_000_000,
  parameter int DEB_CYCLES     = 1_000_000,
  parameter bit RST_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_low_i,
  input  logic aux_low_i,
  input  logic batt_gt_vcc_i,
  input  logic mr_btn_n_i,
  output logic sys_rst_o,
  output logic vcc_warn_o,
  output logic aux_ok_o,
  output logic batt_sel_o
);
  import sup_pkg::*;

  cmp_t              raw_in;
  cmp_t              syn;
  logic [CMP_W-1:0]  syn_v;
  logic              btn_level;
  logic              btn_pressed;
  logic              hold;
  logic              rst_act;
  logic              warn_q;
  logic              aux_ok_q;
  logic              batt_q;

  always_comb begin
    raw_in.vcc_low = vcc_low_i;
    raw_in.aux_low = aux_low_i;
    raw_in.batt_gt = batt_gt_vcc_i;
    raw_in.btn_n   = mr_btn_n_i;
  end

  sup_sync #(.W(CMP_W), .STAGES(2), .RST_VAL(CMP_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_v)
  );
  assign syn = cmp_t'(syn_v);

  sup_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst   (rst),
    .raw   (syn.btn_n),
    .level (btn_level)
  );
  assign btn_pressed = ~btn_level;
  assign hold        = syn.vcc_low | btn_pressed;

  sup_stretch #(.STAB_CYCLES(STAB_CYCLES)) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .active (rst_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q   <= 1'b1;
      aux_ok_q <= 1'b0;
      batt_q   <= 1'b0;
    end else begin
      warn_q   <= syn.vcc_low;
      aux_ok_q <= ~syn.aux_low;
      batt_q   <= syn.vcc_low & syn.batt_gt;
    end
  end

  generate
    if (RST_ACTIVE_LOW) begin : g_rst_low
      assign sys_rst_o = ~rst_act;
    end else begin : g_rst_high
      assign sys_rst_o = rst_act;
    end
  endgenerate

  assign vcc_warn_o = warn_q;
  assign aux_ok_o   = aux_ok_q;
  assign batt_sel_o = batt_q;

  // R4
  batt_needs_reset_chk: assert property (@(posedge clk) disable iff (rst)
    batt_q |-> rst_act);

  // R2
  warn_needs_reset_chk: assert property (@(posedge clk) disable iff (rst)
    warn_q |-> rst_act);

  // R8
  press_forces_chk: assert property (@(posedge clk) disable iff (rst)
    btn_pressed |=> rst_act);
endmodule

// File: tb/supply_sequencer_bench.sv
`timescale 1ns/1ps
module supply_sequencer_bench;
  localparam int STAB = 40;
  localparam int DEB  = 8;
  localparam bit ALOW = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_low = 1'b1, aux_low = 1'b1, batt_gt = 1'b0, btn_n = 1'b1;
  logic sys_rst, vcc_warn, aux_ok, batt_sel;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;
  string ph = "R1";

  always #2 clk = ~clk;

  supply_sequencer #(.STAB_CYCLES(STAB), .DEB_CYCLES(DEB), .RST_ACTIVE_LOW(ALOW)) u_supply_sequencer (
    .clk(clk), .rst(rst), .vcc_low_i(vcc_low), .aux_low_i(aux_low),
    .batt_gt_vcc_i(batt_gt), .mr_btn_n_i(btn_n), .sys_rst_o(sys_rst),
    .vcc_warn_o(vcc_warn), .aux_ok_o(aux_ok), .batt_sel_o(batt_sel)
  );

  // reference model state derived from the requirements
  logic v1, v2, a1, a2, b1, b2, m1, m2, m_acc;
  int   m_cnt, quiet;
  logic e_warn, e_aok, e_batt;

  function automatic logic exp_reset(int q);
    return (q < STAB);
  endfunction

  function automatic logic pin_level(logic active);
    return ALOW ? ~active : active;
  endfunction

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      v1 = 1; v2 = 1; a1 = 1; a2 = 1; b1 = 0; b2 = 0; m1 = 1; m2 = 1;
      m_acc = 1; m_cnt = 0; quiet = 0;
      e_warn = 1; e_aok = 0; e_batt = 0;
    end else begin
      // reset cause seen at this edge: synchronized low supply or accepted press
      if (v2 || !m_acc) quiet = 0;
      else if (quiet < STAB) quiet++;
      e_warn = v2;
      e_aok  = ~a2;
      e_batt = v2 & b2;
      if (m2 == m_acc) m_cnt = 0;
      else if (m_cnt == DEB - 1) begin m_acc = m2; m_cnt = 0; end
      else m_cnt++;
      v2 = v1; v1 = vcc_low;
      a2 = a1; a1 = aux_low;
      b2 = b1; b1 = batt_gt;
      m2 = m1; m1 = btn_n;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (ph == "R1") begin
        chk("R1 reset", sys_rst, pin_level(1'b1));
        chk("R1 warn",  vcc_warn, 1'b1);
        chk("R1 aux",   aux_ok, 1'b0);
        chk("R1 batt",  batt_sel, 1'b0);
      end else begin
        chk($sformatf("R9/%s reset", ph), sys_rst, pin_level(exp_reset(quiet)));
        chk("R2 warn", vcc_warn, e_warn);
        chk("R3 aux",  aux_ok, e_aok);
        chk("R4 batt", batt_sel, e_batt);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    wait_cyc(4);
    ph = "R5";
    rst = 0;
    vcc_low = 1; aux_low = 0; batt_gt = 1;
    wait_cyc(20);
    // R6: recover, glitch in mid window, then run a full window
    ph = "R6";
    batt_gt = 0;
    vcc_low = 0;
    wait_cyc(STAB / 2);
    vcc_low = 1; wait_cyc(1); vcc_low = 0;
    wait_cyc(STAB + 10);
    // R7: bounces shorter than the debounce length
    ph = "R7";
    for (int i = 1; i < DEB; i++) begin
      btn_n = 0; wait_cyc(i); btn_n = 1; wait_cyc(3);
    end
    wait_cyc(10);
    // R8: accepted press then release, followed by the stretch
    ph = "R8";
    btn_n = 0; wait_cyc(DEB + 20);
    btn_n = 1; wait_cyc(DEB + STAB + 10);
    // R3/R4 corner: battery high while supply fine must not select it
    ph = "R6";
    batt_gt = 1; aux_low = 1; wait_cyc(6);
    vcc_low = 1; wait_cyc(6); batt_gt = 0; wait_cyc(4); vcc_low = 0; aux_low = 0;
    wait_cyc(STAB + 6);
    // random phase
    ph = "R5";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 60 == 0) vcc_low = ~vcc_low;
      if ($urandom % 15 == 0) aux_low = ~aux_low;
      if ($urandom % 10 == 0) batt_gt = ~batt_gt;
      if ($urandom % 25 == 0) btn_n   = ~btn_n;
      wait_cyc(1);
    end
    btn_n = 1; vcc_low = 0;
    wait_cyc(STAB + DEB + 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog at cycle %0d: actual hung expected done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule